// File: doc/BRIEF.md
# Dual-Port Scratch RAM with Relocatable Bank

This block is a 544-word, 16-bit on-chip RAM for a processor datapath. It has two independent access ports, A and B. Each port can read or write one word in every clock cycle, so two accesses complete per cycle with no wait states. Storage is split into three banks: two large banks of 256 words and one small bank of 32 words. An address decoder places each bank in a fixed window of a 16-bit address space. Each access carries a space bit that selects data space or program space.

One of the large banks, bank 0, can move between data space and program space while the block runs. A one-bit placement register controls where it sits. Single-cycle set and clear strobes change that register. Every enabled access is decoded against the map in force in that cycle. An access that lands in no window produces a one-cycle non-maskable interrupt request. The same event also sets a sticky error flag, which software clears through a dedicated input.

Top module: `dual_ram544`

## Requirements
- R1: Every word of the 544 words can be written through either port and later read back unchanged.
- R2: In data space (space bit 0), bank 2 answers at 0x0060–0x007F and bank 1 answers at 0x0300–0x03FF, whatever the placement bit holds.
- R3: Bank 0 answers in data space at 0x0200–0x02FF while the placement bit is 1. It answers in program space (space bit 1) at 0xFF00–0xFFFF while the bit is 0. Both windows reach the same storage, so contents survive a move.
- R4: The placement bit `b0_in_data` is 1 after reset. A set strobe alone makes it 1 from the next cycle, and a clear strobe alone makes it 0 from the next cycle. Both strobes together leave it unchanged. Accesses in the strobe cycle use the old placement.
- R5: Both ports may access in the same cycle. Read data appears on the port's rdata in the cycle after the request and holds until that port's next read.
- R6: A read and a write to the same word in one cycle return the old contents, and the write lands at that clock edge. When both ports write the same word in one cycle, the port B value is kept.
- R7: An enabled access that matches no window drives `nmi_req` high for exactly the next cycle. This holds even when both ports miss in the same cycle. A missing write changes no word, and a missing read returns 0.
- R8: While bank 0 is in program space, data-space accesses to 0x0200–0x02FF are illegal. While it is in data space, program-space accesses to 0xFF00–0xFFFF are illegal.
- R9: `err_flag` rises together with `nmi_req` and stays high until `err_clr` is asserted with no new illegal access. A new illegal access takes priority over a clear in the same cycle.
- R10: After reset, `a_rdata`, `b_rdata`, `nmi_req` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_space | input | 1 | Port A space: 0 data, 1 program |
| a_addr | input | 16 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one cycle after the request |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_space | input | 1 | Port B space: 0 data, 1 program |
| b_addr | input | 16 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one cycle after the request |
| cfg_set | input | 1 | Strobe: place bank 0 in data space |
| cfg_clr | input | 1 | Strobe: place bank 0 in program space |
| err_clr | input | 1 | Clears the sticky error flag |
| b0_in_data | output | 1 | Current placement of bank 0 (1 = data space) |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| err_flag | output | 1 | Sticky illegal-access flag |

## Verification
The assertions assume that every input is a known 0 or 1 at each clock edge once reset is released. They also assume that each strobe is a single-cycle level sampled at the edge, not an edge-detected signal. The bench drives all inputs half a cycle away from the rising edge and holds them for a full cycle. Directed phases and a random phase fire both strobes together, hit both ports on one word, and aim at gaps between windows. Before any read, the bench fills all memory, because stored words are never reset.

// File: rtl/dram_pkg.sv
// Shared types for the dual-port scratch RAM.
// Assumes a 16-bit word address and a one-bit address-space selector.
package dram_pkg;
    typedef enum logic [1:0] {
        SEL_B0   = 2'd0,
        SEL_B1   = 2'd1,
        SEL_B2   = 2'd2,
        SEL_NONE = 2'd3
    } bank_sel_e;

    localparam logic SPACE_DATA = 1'b0;
    localparam logic SPACE_PROG = 1'b1;
endpackage

// File: rtl/dram_decode.sv
// Address decoder for one port: turns (space, address, bank-0 placement)
// into a bank select and an offset within that bank.
// Assumes each window is DEPTH words long and starts at its base.
module dram_decode
    import dram_pkg::*;
#(
    parameter int             AW           = 16,
    parameter int             BIG_DEPTH    = 256,
    parameter int             SMALL_DEPTH  = 32,
    parameter logic [AW-1:0]  B0_DATA_BASE = 16'h0200,
    parameter logic [AW-1:0]  B0_PROG_BASE = 16'hFF00,
    parameter logic [AW-1:0]  B1_BASE      = 16'h0300,
    parameter logic [AW-1:0]  B2_BASE      = 16'h0060
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          space,
    input  logic [AW-1:0] addr,
    input  logic          b0_in_data,
    output bank_sel_e     sel,
    output logic [AW-1:0] off
);
    localparam logic [AW-1:0] BIG_L   = AW'(BIG_DEPTH);
    localparam logic [AW-1:0] SMALL_L = AW'(SMALL_DEPTH);

    logic [AW-1:0] off_b0d, off_b0p, off_b1, off_b2;

    // Offsets of the address from every window base.
    always_comb begin
        off_b0d = addr - B0_DATA_BASE;
        off_b0p = addr - B0_PROG_BASE;
        off_b1  = addr - B1_BASE;
        off_b2  = addr - B2_BASE;
    end

    // Pick the window that holds the address in the current map.
    always_comb begin
        sel = SEL_NONE;
        off = '0;
        if (space == SPACE_DATA) begin
            if (b0_in_data && (off_b0d < BIG_L)) begin
                sel = SEL_B0;
                off = off_b0d;
            end else if (off_b1 < BIG_L) begin
                sel = SEL_B1;
                off = off_b1;
            end else if (off_b2 < SMALL_L) begin
                sel = SEL_B2;
                off = off_b2;
            end
        end else if (!b0_in_data && (off_b0p < BIG_L)) begin
            sel = SEL_B0;
            off = off_b0p;
        end
    end

    // Program space reaches only bank 0, and only while bank 0 is placed there.
    assert_prog_only_b0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (space == SPACE_PROG && sel != SEL_NONE) |-> (sel == SEL_B0 && !b0_in_data));

    // Bank 0 is never selected in data space while it is placed in program space.
    assert_b0_data_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (space == SPACE_DATA && !b0_in_data) |-> (sel != SEL_B0));
endmodule

// File: rtl/dram_bank.sv
// One storage bank with two synchronous ports.
// A read returns the word held before this edge's writes land.
// When both ports write the same index, port B is kept.
// Assumes callers gate the enables with the bank select.
module dram_bank #(
    parameter int DEPTH = 256,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_re,
    input  logic          a_wr,
    input  logic [IW-1:0] a_idx,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic          b_re,
    input  logic          b_wr,
    input  logic [IW-1:0] b_idx,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);
    logic [DW-1:0] mem [DEPTH];

    // Both ports read the old contents first, then the writes land (B last).
    always_ff @(posedge clk) begin
        if (a_re) a_rd <= mem[a_idx];
        if (b_re) b_rd <= mem[b_idx];
        if (a_wr) mem[a_idx] <= a_wd;
        if (b_wr) mem[b_idx] <= b_wd;
    end
endmodule

// File: rtl/dram_ctl.sv
// Placement register for bank 0 plus the illegal-access reporting:
// a one-cycle interrupt request and a sticky flag.
// Assumes ill_a and ill_b are already gated by the port enables.
module dram_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_set,
    input  logic cfg_clr,
    input  logic ill_a,
    input  logic ill_b,
    input  logic err_clr,
    output logic b0_in_data,
    output logic nmi_req,
    output logic err_flag
);
    // Placement bit: a lone set or a lone clear changes it; both together hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                    b0_in_data <= 1'b1;
        else if (cfg_set && !cfg_clr)  b0_in_data <= 1'b1;
        else if (cfg_clr && !cfg_set)  b0_in_data <= 1'b0;
    end

    // One request pulse per cycle that holds any illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= ill_a | ill_b;
    end

    // Sticky flag: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             err_flag <= 1'b0;
        else if (ill_a | ill_b) err_flag <= 1'b1;
        else if (err_clr)       err_flag <= 1'b0;
    end

    assert_cfg_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_set && !cfg_clr) |=> b0_in_data);
    assert_cfg_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clr && !cfg_set) |=> !b0_in_data);
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_set == cfg_clr) |=> $stable(b0_in_data));
    assert_nmi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_a || ill_b) |=> nmi_req);
    assert_nmi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_a || ill_b) |=> !nmi_req);
    assert_err_with_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> err_flag);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: rtl/dual_ram544.sv
// Top of the dual-port scratch RAM: two decoders (one per port), three
// banks, and the placement and reporting control. Read data is registered
// once and holds between reads. Missing reads return zero, and missing
// writes are dropped. Assumes all inputs are known at every clock edge.
module dual_ram544
    import dram_pkg::*;
#(
    parameter int             AW           = 16,
    parameter int             DW           = 16,
    parameter int             BIG_DEPTH    = 256,
    parameter int             SMALL_DEPTH  = 32,
    parameter logic [AW-1:0]  B0_DATA_BASE = 16'h0200,
    parameter logic [AW-1:0]  B0_PROG_BASE = 16'hFF00,
    parameter logic [AW-1:0]  B1_BASE      = 16'h0300,
    parameter logic [AW-1:0]  B2_BASE      = 16'h0060
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic          a_space,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic          b_space,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    input  logic          cfg_set,
    input  logic          cfg_clr,
    input  logic          err_clr,
    output logic          b0_in_data,
    output logic          nmi_req,
    output logic          err_flag
);
    localparam int NPORT = 2;
    localparam int NBANK = 3;

    logic          p_en    [NPORT];
    logic          p_we    [NPORT];
    logic          p_space [NPORT];
    logic [AW-1:0] p_addr  [NPORT];
    logic [DW-1:0] p_wd    [NPORT];
    logic [DW-1:0] p_rd    [NPORT];
    logic          p_ill   [NPORT];
    logic          p_rdreq [NPORT];
    bank_sel_e     p_sel   [NPORT];
    bank_sel_e     p_sel_q [NPORT];
    logic [AW-1:0] p_off   [NPORT];
    logic [DW-1:0] bank_rd [NBANK][NPORT];

    // Gather the two ports into arrays so the rest is generated.
    always_comb begin
        p_en[0] = a_en;   p_we[0] = a_we;   p_space[0] = a_space;
        p_addr[0] = a_addr; p_wd[0] = a_wdata;
        p_en[1] = b_en;   p_we[1] = b_we;   p_space[1] = b_space;
        p_addr[1] = b_addr; p_wd[1] = b_wdata;
        a_rdata = p_rd[0];
        b_rdata = p_rd[1];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dram_decode #(
            .AW(AW), .BIG_DEPTH(BIG_DEPTH), .SMALL_DEPTH(SMALL_DEPTH),
            .B0_DATA_BASE(B0_DATA_BASE), .B0_PROG_BASE(B0_PROG_BASE),
            .B1_BASE(B1_BASE), .B2_BASE(B2_BASE)
        ) u_dec (
            .clk(clk), .rst_n(rst_n), .space(p_space[p]), .addr(p_addr[p]),
            .b0_in_data(b0_in_data), .sel(p_sel[p]), .off(p_off[p])
        );

        // Flag enabled accesses that miss every window, and mark reads.
        always_comb begin
            p_ill[p]   = p_en[p] && (p_sel[p] == SEL_NONE);
            p_rdreq[p] = p_en[p] && !p_we[p];
        end

        // Remember which bank feeds this port's read data (NONE gives zero).
        always_ff @(posedge clk) begin
            if (!rst_n)          p_sel_q[p] <= SEL_NONE;
            else if (p_rdreq[p]) p_sel_q[p] <= p_sel[p];
        end

        // Steer the remembered bank's read register to the port.
        always_comb begin
            case (p_sel_q[p])
                SEL_B0:  p_rd[p] = bank_rd[0][p];
                SEL_B1:  p_rd[p] = bank_rd[1][p];
                SEL_B2:  p_rd[p] = bank_rd[2][p];
                default: p_rd[p] = '0;
            endcase
        end

        assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (p_rdreq[p] && p_ill[p]) |=> (p_rd[p] == '0));
        assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !p_rdreq[p] |=> $stable(p_rd[p]));
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam int D  = (g == NBANK - 1) ? SMALL_DEPTH : BIG_DEPTH;
        localparam int IW = $clog2(D);
        logic hit_a, hit_b;

        // Route each port to this bank only when its decoder selects it.
        always_comb begin
            hit_a = p_en[0] && (p_sel[0] == bank_sel_e'(g));
            hit_b = p_en[1] && (p_sel[1] == bank_sel_e'(g));
        end

        dram_bank #(.DEPTH(D), .DW(DW)) u_bank (
            .clk(clk),
            .a_re(hit_a && !p_we[0]), .a_wr(hit_a && p_we[0]),
            .a_idx(p_off[0][IW-1:0]), .a_wd(p_wd[0]), .a_rd(bank_rd[g][0]),
            .b_re(hit_b && !p_we[1]), .b_wr(hit_b && p_we[1]),
            .b_idx(p_off[1][IW-1:0]), .b_wd(p_wd[1]), .b_rd(bank_rd[g][1])
        );
    end

    dram_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_set(cfg_set), .cfg_clr(cfg_clr),
        .ill_a(p_ill[0]), .ill_b(p_ill[1]), .err_clr(err_clr),
        .b0_in_data(b0_in_data), .nmi_req(nmi_req), .err_flag(err_flag)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0 && !nmi_req && !err_flag));
endmodule

// File: tb/dual_ram544_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model advanced at each rising edge
// and compared with every output half a cycle later.
module dual_ram544_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_en, a_we, a_space, b_en, b_we, b_space;
    logic [15:0] a_addr, a_wdata, b_addr, b_wdata;
    logic [15:0] a_rdata, b_rdata;
    logic        cfg_set, cfg_clr, err_clr;
    logic        b0_in_data, nmi_req, err_flag;

    dual_ram544 u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_space(a_space), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_space(b_space), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata),
        .cfg_set(cfg_set), .cfg_clr(cfg_clr), .err_clr(err_clr),
        .b0_in_data(b0_in_data), .nmi_req(nmi_req), .err_flag(err_flag)
    );

    always #2.5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R10";

    // Reference model state.
    int          m_mem [544];
    logic [15:0] m_rd_a, m_rd_b;
    logic        m_cfg, m_nmi, m_err;

    function automatic int mdec(logic sp, logic [15:0] ad, logic c);
        int a = int'(ad);
        if (sp == 1'b0) begin
            if (c && a >= 'h200 && a <= 'h2FF) return a - 'h200;
            if (a >= 'h300 && a <= 'h3FF)      return 256 + a - 'h300;
            if (a >= 'h060 && a <= 'h07F)      return 512 + a - 'h060;
            return -1;
        end
        if (!c && a >= 'hFF00) return a - 'hFF00;
        return -1;
    endfunction

    function automatic logic [15:0] data_addr(int idx);
        if (idx < 256) return 16'(32'h200 + idx);
        if (idx < 512) return 16'(32'h300 + idx - 256);
        return 16'(32'h060 + idx - 512);
    endfunction

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int  ia, ib;
        bit  ill;
        if (!rst_n) begin
            m_rd_a = '0; m_rd_b = '0; m_nmi = 0; m_err = 0; m_cfg = 1;
            return;
        end
        ia = mdec(a_space, a_addr, m_cfg);
        ib = mdec(b_space, b_addr, m_cfg);
        if (a_en && !a_we) m_rd_a = (ia >= 0) ? 16'(m_mem[ia]) : 16'h0;
        if (b_en && !b_we) m_rd_b = (ib >= 0) ? 16'(m_mem[ib]) : 16'h0;
        ill = (a_en && ia < 0) || (b_en && ib < 0);
        m_nmi = ill;
        if (ill) m_err = 1;
        else if (err_clr) m_err = 0;
        if (a_en && a_we && ia >= 0) m_mem[ia] = int'(a_wdata);
        if (b_en && b_we && ib >= 0) m_mem[ib] = int'(b_wdata);
        if (cfg_set && !cfg_clr) m_cfg = 1;
        else if (cfg_clr && !cfg_set) m_cfg = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("a_rdata", a_rdata, m_rd_a);
        chk("b_rdata", b_rdata, m_rd_b);
        chk("nmi_req", {15'b0, nmi_req}, {15'b0, m_nmi});
        chk("err_flag", {15'b0, err_flag}, {15'b0, m_err});
        chk("b0_in_data", {15'b0, b0_in_data}, {15'b0, m_cfg});
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; a_space = 0; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_space = 0; b_addr = '0; b_wdata = '0;
        cfg_set = 0; cfg_clr = 0; err_clr = 0;
    endtask

    task automatic acc_a(logic we, logic sp, logic [15:0] ad, logic [15:0] wd);
        a_en = 1; a_we = we; a_space = sp; a_addr = ad; a_wdata = wd;
    endtask

    task automatic acc_b(logic we, logic sp, logic [15:0] ad, logic [15:0] wd);
        b_en = 1; b_we = we; b_space = sp; b_addr = ad; b_wdata = wd;
    endtask

    function automatic logic [15:0] rnd_addr();
        case ($urandom % 6)
            0: return 16'(32'h060 + ($urandom % 32));
            1: return 16'(32'h200 + ($urandom % 256));
            2: return 16'(32'h300 + ($urandom % 256));
            3: return 16'(32'hFF00 + ($urandom % 256));
            4: return 16'(32'h400 + ($urandom % 64));
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        m_cfg = 1;
        for (int i = 0; i < 544; i++) m_mem[i] = 0;
        @(negedge clk);
        // R10: reset state over several cycles.
        cur_req = "R10";
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1;
        cyc();

        // R1, R2, R3: fill all 544 words through both ports in data space.
        cur_req = "R1";
        for (int i = 0; i < 272; i++) begin
            acc_a(1, 0, data_addr(2 * i), 16'((2 * i) * 40503 ^ 23130));
            acc_b(1, 0, data_addr(2 * i + 1), 16'((2 * i + 1) * 40503 ^ 23130));
            cyc();
        end
        // R5: read everything back, two reads per cycle, in reverse on B.
        cur_req = "R5";
        for (int i = 0; i < 544; i++) begin
            acc_a(0, 0, data_addr(i), '0);
            acc_b(0, 0, data_addr(543 - i), '0);
            cyc();
        end
        idle(); cyc(); cyc();  // R5 hold check

        // R4: clear strobe moves bank 0 to program space.
        cur_req = "R4";
        cfg_clr = 1; acc_a(0, 0, 16'h0205, '0); cyc();  // old map still used
        idle(); cyc();
        // R3: program window reads the same storage.
        cur_req = "R3";
        acc_a(0, 1, 16'hFF05, '0); acc_b(0, 1, 16'hFFFF, '0); cyc();
        acc_a(1, 1, 16'hFF07, 16'hBEEF); cyc();
        // R8: old data window is now illegal.
        cur_req = "R8";
        idle(); acc_b(0, 0, 16'h0210, '0); cyc();
        idle(); acc_a(1, 0, 16'h0211, 16'h1234); cyc();
        idle(); cyc();
        // R4: both strobes together hold; then set returns bank 0.
        cur_req = "R4";
        cfg_set = 1; cfg_clr = 1; cyc();
        idle(); cfg_set = 1; cyc();
        idle(); cyc();
        cur_req = "R3";
        acc_a(0, 0, 16'h0207, '0); acc_b(0, 0, 16'h0211, '0); cyc();
        // R8: program window illegal again.
        cur_req = "R8";
        idle(); acc_a(1, 1, 16'hFF11, 16'hDEAD); cyc();
        idle(); acc_b(0, 0, 16'h0211, '0); cyc();

        // R6: same-word read and write in one cycle.
        cur_req = "R6";
        idle(); acc_a(1, 0, 16'h0300, 16'hA5A5); acc_b(0, 0, 16'h0300, '0); cyc();
        idle(); acc_b(0, 0, 16'h0300, '0); cyc();
        idle(); acc_a(1, 0, 16'h007F, 16'h1111); acc_b(1, 0, 16'h007F, 16'h2222); cyc();
        idle(); acc_a(0, 0, 16'h007F, '0); cyc();

        // R7: misses on both ports, gaps between windows.
        cur_req = "R7";
        idle(); acc_a(0, 0, 16'h0000, '0); acc_b(1, 0, 16'h0400, 16'h7777); cyc();
        idle(); cyc();
        idle(); acc_a(0, 1, 16'h0060, '0); cyc();
        idle(); acc_a(0, 0, 16'h005F, '0); acc_b(0, 0, 16'h0080, '0); cyc();
        // R9: sticky until clear; new event wins over clear.
        cur_req = "R9";
        idle(); for (int i = 0; i < 3; i++) cyc();
        err_clr = 1; cyc();
        idle(); cyc();
        acc_a(0, 0, 16'h01FF, '0); err_clr = 1; cyc();
        idle(); err_clr = 1; cyc();
        idle(); cyc();

        // R2, R7: random mix.
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            idle();
            if ($urandom % 4 != 0) acc_a(1'($urandom), 1'($urandom % 4 == 0), rnd_addr(), 16'($urandom));
            if ($urandom % 4 != 0) acc_b(1'($urandom), 1'($urandom % 4 == 0), rnd_addr(), 16'($urandom));
            cfg_set = ($urandom % 16 == 0);
            cfg_clr = ($urandom % 16 == 0);
            err_clr = ($urandom % 8 == 0);
            cyc();
        end
        idle(); cyc();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule